// File: doc/BRIEF.md
# Two-Socket Card Bridge Configuration Header

This block is the configuration register file of a card bridge that serves two sockets. Each socket is its own configuration function, so the block holds two separate register sets. A single configuration port reaches them. Each access carries a function select, a dword index, four byte enables and write data. Read data comes back one clock later.

Each function owns the following registers:
- a three-bit enable register for I/O space, memory space and bus mastering;
- a 4 KB-aligned socket register base;
- two memory windows and two I/O windows, each with a base and a limit;
- an interrupt line byte;
- a bridge control field.

Constant identity words sit at fixed dwords. One of them is the header type byte, which reads as a type 2 header with the multifunction flag set.

Only one writable register is shared by the two functions: the legacy I/O base at byte offset 0x44. A write through either function is visible through both. While that base is non-zero, the bridge is in legacy mode. In legacy mode it claims two consecutive I/O ports at the base: the even port is the index port and the odd port is the data port. A base of zero puts the bridge in card-bus mode, and the bridge then claims no legacy ports.

Top module: `cbCfgHeader`

## Requirements
- R1: After reset, every enable register, socket base and window register reads 0. Each interrupt line reads 0xFF. The shared legacy base reads 0x03E0, so `legacyMode` is 1.
- R2: The enable register sits at dword 1 (offset 0x04). Bit 0 is I/O enable, bit 1 is memory enable and bit 2 is bus master enable. Writing 0x07 sets all three. Bits 31:3 read 0. `sockIoEn[f]`, `sockMemEn[f]` and `sockMasterEn[f]` show bits 0, 1 and 2 of function f, starting the cycle after the write.
- R3: A write through function f to the enable register, socket base, a window, the interrupt line or bridge control never changes any register of the other function.
- R4: The legacy base at dword 17 (offset 0x44) is shared. Bits 15:1 are writable, and all other bits read 0. A value written through either function reads back through both.
- R5: The socket base at dword 4 (offset 0x10) has bits 11:0 forced to 0. The memory windows at dwords 7 to 10 keep bits 31:12. The I/O windows at dwords 11 to 14 keep bits 31:2.
- R6: The following dwords are read-only constants:
  - dword 0 reads 0x1A2B3C4D;
  - dword 2 reads 0x06070000;
  - dword 3 reads 0x00820000, which is header type 0x82 in byte 2.
- R7: Dwords 5, 6, 16 and 18 to 63 read 0, and writes to them change nothing.
- R8: On a write, byte lane n (bits 8n+7:8n) changes only when byte enable n is 1.
- R9: `legacyMode` is 1 exactly when legacy base bits 15:1 are non-zero. With `ioValid` high in legacy mode:
  - an address equal to the even base raises `legacyIndexSel`;
  - the next address up raises `legacyDataSel`;
  - any other address raises neither.
  In card-bus mode, neither select is raised.
- R10: A read raises `cfgRdValid` one cycle later, with `cfgRdData` set to the register contents from before any write in the same cycle.
- R11: Dword 15 (offset 0x3C) holds three fields:
  - bits 7:0 are the writable interrupt line;
  - bits 15:8 are the read-only interrupt pin, which is 1 for function 0 and 2 for function 1;
  - bits 26:16 are the writable bridge control, and bits 31:27 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write request |
| cfgRdEn | input | 1 | Configuration read request |
| cfgFunc | input | 1 | Function (socket) select |
| cfgDwAddr | input | 6 | Dword index within the header |
| cfgByteEn | input | 4 | Write byte lane enables |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Read data, one cycle after the request |
| cfgRdValid | output | 1 | Read data valid |
| ioValid | input | 1 | An I/O address is presented |
| ioAddr | input | 16 | I/O address to decode |
| legacyMode | output | 1 | Legacy base is non-zero |
| legacyIndexSel | output | 1 | Legacy index port addressed |
| legacyDataSel | output | 1 | Legacy data port addressed |
| sockIoEn | output | 2 | I/O enable per socket |
| sockMemEn | output | 2 | Memory enable per socket |
| sockMasterEn | output | 2 | Bus master enable per socket |

## Verification
A read and a write may share a cycle, with the same or different function and dword. The read must return the state from before the write. The bench raises both requests together in most random operations. The expected read value comes from the bench model before the write is applied, and the model is updated only after the comparison.

A write to the shared legacy base also falls in the same cycle as the legacy port decode. The bench moves the base and then probes the old and new port pairs. This confirms that the selects follow the new base from the next cycle onward.

// File: rtl/cbCfgPkg.sv
package cbCfgPkg;

  localparam int NUM_FUNC     = 2;
  localparam int NUM_WIN      = 8;
  localparam int NUM_MEM_WIN  = 4;
  localparam int DW_ID        = 0;
  localparam int DW_CMD       = 1;
  localparam int DW_CLASS     = 2;
  localparam int DW_HDR       = 3;
  localparam int DW_SOCK      = 4;
  localparam int DW_WIN_FIRST = 7;
  localparam int DW_INTBC     = 15;
  localparam int DW_LEGACY    = 17;

  typedef enum logic [3:0] {
    RD_ZERO, RD_ID, RD_CMD, RD_CLASS, RD_HDR, RD_SOCK, RD_WIN, RD_INTBC, RD_LEGACY
  } rdSel_e;

  typedef struct packed {
    logic               wrCmd;
    logic               wrSock;
    logic [NUM_WIN-1:0] wrWin;
    logic               wrIntBc;
    logic               wrLegacy;
    logic               func;
    logic [3:0]         byteEn;
    logic               rdEn;
    rdSel_e             rdSel;
    logic [2:0]         winIdx;
  } cfgStrobe_t;

  function automatic logic [31:0] laneMerge(input logic [31:0] oldVal,
                                            input logic [31:0] newVal,
                                            input logic [3:0]  be);
    logic [31:0] res;
    for (int i = 0; i < 4; i++) begin
      res[i*8 +: 8] = be[i] ? newVal[i*8 +: 8] : oldVal[i*8 +: 8];
    end
    return res;
  endfunction

endpackage

// File: rtl/cbCfgCtrl.sv
module cbCfgCtrl
  import cbCfgPkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgRdEn,
  input  logic              cfgFunc,
  input  logic [ADDR_W-1:0] cfgDwAddr,
  input  logic [3:0]        cfgByteEn,
  output cfgStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] A_ID     = ADDR_W'(DW_ID);
  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(DW_CMD);
  localparam logic [ADDR_W-1:0] A_CLASS  = ADDR_W'(DW_CLASS);
  localparam logic [ADDR_W-1:0] A_HDR    = ADDR_W'(DW_HDR);
  localparam logic [ADDR_W-1:0] A_SOCK   = ADDR_W'(DW_SOCK);
  localparam logic [ADDR_W-1:0] A_WIN_LO = ADDR_W'(DW_WIN_FIRST);
  localparam logic [ADDR_W-1:0] A_WIN_HI = ADDR_W'(DW_WIN_FIRST + NUM_WIN - 1);
  localparam logic [ADDR_W-1:0] A_INTBC  = ADDR_W'(DW_INTBC);
  localparam logic [ADDR_W-1:0] A_LEGACY = ADDR_W'(DW_LEGACY);

  logic              isWin;
  logic [ADDR_W-1:0] winOff;

  assign isWin  = (cfgDwAddr >= A_WIN_LO) && (cfgDwAddr <= A_WIN_HI);
  assign winOff = cfgDwAddr - A_WIN_LO;

  always_comb begin
    strobe        = '0;
    strobe.func   = cfgFunc;
    strobe.byteEn = cfgByteEn;
    strobe.rdEn   = cfgRdEn;
    strobe.rdSel  = RD_ZERO;
    strobe.winIdx = winOff[2:0];
    if (cfgDwAddr == A_ID) begin
      strobe.rdSel = RD_ID;
    end else if (cfgDwAddr == A_CMD) begin
      strobe.rdSel = RD_CMD;
      strobe.wrCmd = cfgWrEn;
    end else if (cfgDwAddr == A_CLASS) begin
      strobe.rdSel = RD_CLASS;
    end else if (cfgDwAddr == A_HDR) begin
      strobe.rdSel = RD_HDR;
    end else if (cfgDwAddr == A_SOCK) begin
      strobe.rdSel  = RD_SOCK;
      strobe.wrSock = cfgWrEn;
    end else if (isWin) begin
      strobe.rdSel = RD_WIN;
      strobe.wrWin[winOff[2:0]] = cfgWrEn;
    end else if (cfgDwAddr == A_INTBC) begin
      strobe.rdSel   = RD_INTBC;
      strobe.wrIntBc = cfgWrEn;
    end else if (cfgDwAddr == A_LEGACY) begin
      strobe.rdSel    = RD_LEGACY;
      strobe.wrLegacy = cfgWrEn;
    end
  end

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrCmd, strobe.wrSock, strobe.wrWin, strobe.wrIntBc, strobe.wrLegacy})); // R7

  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |-> !(strobe.wrCmd || strobe.wrSock || (|strobe.wrWin) ||
                   strobe.wrIntBc || strobe.wrLegacy)); // R7

endmodule

// File: rtl/cbCfgDatapath.sv
module cbCfgDatapath
  import cbCfgPkg::*;
#(
  parameter logic [31:0] ID_WORD       = 32'h1A2B_3C4D,
  parameter logic [31:0] CLASS_WORD    = 32'h0607_0000,
  parameter logic [15:0] LEGACY_RESET  = 16'h03E0,
  parameter logic [15:0] BRIDGE_MASK   = 16'h07FF
) (
  input  logic                clk,
  input  logic                rstN,
  input  cfgStrobe_t          strobe,
  input  logic [31:0]         wrData,
  output logic [31:0]         rdData,
  output logic                rdValid,
  output logic [15:0]         legacyBase,
  output logic [NUM_FUNC-1:0] ioEn,
  output logic [NUM_FUNC-1:0] memEn,
  output logic [NUM_FUNC-1:0] masterEn
);

  localparam logic [31:0] MEM_WIN_MASK = 32'hFFFF_F000;
  localparam logic [31:0] IO_WIN_MASK  = 32'hFFFF_FFFC;
  localparam logic [31:0] SOCK_MASK    = 32'hFFFF_F000;
  localparam logic [15:0] LEGACY_MASK  = 16'hFFFE;

  logic [2:0]  cmdReg    [NUM_FUNC];
  logic [31:0] sockBase  [NUM_FUNC];
  logic [31:0] winReg    [NUM_FUNC][NUM_WIN];
  logic [7:0]  intLine   [NUM_FUNC];
  logic [15:0] bridgeCtl [NUM_FUNC];

  logic [31:0] oldCmd, oldSock, oldWin, oldIntBc, oldLegacy;
  logic [31:0] newCmd, newSock, newWin, newIntBc, newLegacy;
  logic [7:0]  intPin;
  logic [31:0] rdNext;

  assign intPin = 8'(strobe.func) + 8'd1;

  always_comb begin
    oldCmd    = {29'b0, cmdReg[strobe.func]};
    oldSock   = sockBase[strobe.func];
    oldWin    = winReg[strobe.func][strobe.winIdx];
    oldIntBc  = {bridgeCtl[strobe.func], intPin, intLine[strobe.func]};
    oldLegacy = {16'b0, legacyBase};
    newCmd    = laneMerge(oldCmd,    wrData, strobe.byteEn);
    newSock   = laneMerge(oldSock,   wrData, strobe.byteEn) & SOCK_MASK;
    newWin    = laneMerge(oldWin,    wrData, strobe.byteEn);
    newIntBc  = laneMerge(oldIntBc,  wrData, strobe.byteEn);
    newLegacy = laneMerge(oldLegacy, wrData, strobe.byteEn);
  end

  for (genvar f = 0; f < NUM_FUNC; f++) begin : gFunc
    logic fnSel;
    assign fnSel = (strobe.func == 1'(f));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmdReg[f]    <= '0;
        sockBase[f]  <= '0;
        intLine[f]   <= 8'hFF;
        bridgeCtl[f] <= '0;
      end else if (fnSel) begin
        if (strobe.wrCmd)   cmdReg[f]    <= newCmd[2:0];
        if (strobe.wrSock)  sockBase[f]  <= newSock;
        if (strobe.wrIntBc) begin
          intLine[f]   <= newIntBc[7:0];
          bridgeCtl[f] <= newIntBc[31:16] & BRIDGE_MASK;
        end
      end
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : gWin
      localparam logic [31:0] W_MASK = (w < NUM_MEM_WIN) ? MEM_WIN_MASK : IO_WIN_MASK;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          winReg[f][w] <= '0;
        end else if (fnSel && strobe.wrWin[w]) begin
          winReg[f][w] <= newWin & W_MASK;
        end
      end
    end

    assign ioEn[f]     = cmdReg[f][0];
    assign memEn[f]    = cmdReg[f][1];
    assign masterEn[f] = cmdReg[f][2];

    AST_SOCK_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
      sockBase[f][11:0] == 12'h000); // R5

    AST_OTHER_FN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.func != 1'(f)) |=> $stable(cmdReg[f]) && $stable(bridgeCtl[f])
                                  && $stable(intLine[f])); // R3
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      legacyBase <= LEGACY_RESET;
    end else if (strobe.wrLegacy) begin
      legacyBase <= newLegacy[15:0] & LEGACY_MASK;
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_ID:     rdNext = ID_WORD;
      RD_CMD:    rdNext = oldCmd;
      RD_CLASS:  rdNext = CLASS_WORD;
      RD_HDR:    rdNext = 32'h0082_0000;
      RD_SOCK:   rdNext = oldSock;
      RD_WIN:    rdNext = oldWin;
      RD_INTBC:  rdNext = oldIntBc;
      RD_LEGACY: rdNext = oldLegacy;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.rdEn;
      if (strobe.rdEn) rdData <= rdNext;
    end
  end

  AST_LEGACY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrLegacy |=> $stable(legacyBase)); // R4

  AST_LEGACY_BIT0: assert property (@(posedge clk) disable iff (!rstN)
    legacyBase[0] == 1'b0); // R4

  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn |=> rdValid); // R10

endmodule

// File: rtl/cbLegacyDecode.sv
module cbLegacyDecode #(
  parameter int IO_ADDR_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [IO_ADDR_W-1:0] legacyBase,
  input  logic                 ioValid,
  input  logic [IO_ADDR_W-1:0] ioAddr,
  output logic                 legacyMode,
  output logic                 indexSel,
  output logic                 dataSel
);

  logic pairHit;

  assign legacyMode = |legacyBase[IO_ADDR_W-1:1];
  assign pairHit    = ioValid && legacyMode &&
                      (ioAddr[IO_ADDR_W-1:1] == legacyBase[IO_ADDR_W-1:1]);
  assign indexSel   = pairHit && !ioAddr[0];
  assign dataSel    = pairHit &&  ioAddr[0];

  AST_SEL_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (indexSel || dataSel) |-> legacyMode); // R9

  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({indexSel, dataSel})); // R9

endmodule

// File: rtl/cbCfgHeader.sv
module cbCfgHeader
  import cbCfgPkg::*;
#(
  parameter int          ADDR_W       = 6,
  parameter int          IO_ADDR_W    = 16,
  parameter logic [31:0] ID_WORD      = 32'h1A2B_3C4D,
  parameter logic [31:0] CLASS_WORD   = 32'h0607_0000,
  parameter logic [15:0] LEGACY_RESET = 16'h03E0,
  parameter logic [15:0] BRIDGE_MASK  = 16'h07FF
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic                 cfgRdEn,
  input  logic                 cfgFunc,
  input  logic [ADDR_W-1:0]    cfgDwAddr,
  input  logic [3:0]           cfgByteEn,
  input  logic [31:0]          cfgWrData,
  output logic [31:0]          cfgRdData,
  output logic                 cfgRdValid,
  input  logic                 ioValid,
  input  logic [IO_ADDR_W-1:0] ioAddr,
  output logic                 legacyMode,
  output logic                 legacyIndexSel,
  output logic                 legacyDataSel,
  output logic [1:0]           sockIoEn,
  output logic [1:0]           sockMemEn,
  output logic [1:0]           sockMasterEn
);

  cfgStrobe_t  strobe;
  logic [15:0] legacyBase;

  cbCfgCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn),
    .cfgFunc(cfgFunc), .cfgDwAddr(cfgDwAddr), .cfgByteEn(cfgByteEn),
    .strobe(strobe)
  );

  cbCfgDatapath #(
    .ID_WORD(ID_WORD), .CLASS_WORD(CLASS_WORD),
    .LEGACY_RESET(LEGACY_RESET), .BRIDGE_MASK(BRIDGE_MASK)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(cfgWrData),
    .rdData(cfgRdData), .rdValid(cfgRdValid), .legacyBase(legacyBase),
    .ioEn(sockIoEn), .memEn(sockMemEn), .masterEn(sockMasterEn)
  );

  cbLegacyDecode #(.IO_ADDR_W(IO_ADDR_W)) uLegacy (
    .clk(clk), .rstN(rstN), .legacyBase(IO_ADDR_W'(legacyBase)),
    .ioValid(ioValid), .ioAddr(ioAddr), .legacyMode(legacyMode),
    .indexSel(legacyIndexSel), .dataSel(legacyDataSel)
  );

endmodule

// File: tb/cbCfgHeader_test.sv
`timescale 1ns/1ps
module cbCfgHeader_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0, cfgRdEn = 1'b0, cfgFunc = 1'b0;
  logic [5:0]  cfgDwAddr = '0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        cfgRdValid;
  logic        ioValid = 1'b0;
  logic [15:0] ioAddr = '0;
  logic        legacyMode, legacyIndexSel, legacyDataSel;
  logic [1:0]  sockIoEn, sockMemEn, sockMasterEn;

  int total = 0;
  int bad   = 0;
  logic [31:0] mRegs [2][20];
  logic [15:0] mLeg;

  always #10 clk = ~clk;

  cbCfgHeader uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn),
    .cfgFunc(cfgFunc), .cfgDwAddr(cfgDwAddr), .cfgByteEn(cfgByteEn),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .cfgRdValid(cfgRdValid),
    .ioValid(ioValid), .ioAddr(ioAddr), .legacyMode(legacyMode),
    .legacyIndexSel(legacyIndexSel), .legacyDataSel(legacyDataSel),
    .sockIoEn(sockIoEn), .sockMemEn(sockMemEn), .sockMasterEn(sockMasterEn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wMask(input int idx);
    if (idx == 1) return 32'h0000_0007;
    if (idx == 4) return 32'hFFFF_F000;
    if (idx >= 7 && idx <= 10) return 32'hFFFF_F000;
    if (idx >= 11 && idx <= 14) return 32'hFFFF_FFFC;
    if (idx == 15) return 32'h07FF_00FF;
    if (idx == 17) return 32'h0000_FFFE;
    return 32'h0;
  endfunction

  function automatic logic [31:0] mRead(input int f, input int idx);
    case (idx)
      0: return 32'h1A2B_3C4D;
      2: return 32'h0607_0000;
      3: return 32'h0082_0000;
      15: return {mRegs[f][15][31:16], 8'(f + 1), mRegs[f][15][7:0]};
      17: return {16'h0, mLeg};
      1, 4, 7, 8, 9, 10, 11, 12, 13, 14: return mRegs[f][idx];
      default: return 32'h0;
    endcase
  endfunction

  task automatic mWrite(input int f, input int idx, input logic [3:0] be, input logic [31:0] d);
    logic [31:0] cur, nxt;
    cur = mRead(f, idx);
    for (int i = 0; i < 4; i++) nxt[i*8 +: 8] = be[i] ? d[i*8 +: 8] : cur[i*8 +: 8];
    nxt = nxt & wMask(idx);
    if (idx == 17) mLeg = nxt[15:0];
    else if (idx < 20 && wMask(idx) != 0) mRegs[f][idx] = nxt;
  endtask

  task automatic modelReset();
    for (int f = 0; f < 2; f++)
      for (int i = 0; i < 20; i++) mRegs[f][i] = (i == 15) ? 32'h0000_00FF : 32'h0;
    mLeg = 16'h03E0;
  endtask

  // one access; returns the read data captured at the edge
  task automatic access(input logic wr, input logic rd, input int f, input int idx,
                        input logic [3:0] be, input logic [31:0] d, output logic [31:0] q,
                        output logic v);
    @(negedge clk);
    cfgWrEn = wr; cfgRdEn = rd; cfgFunc = 1'(f); cfgDwAddr = 6'(idx);
    cfgByteEn = be; cfgWrData = d;
    @(posedge clk);
    @(negedge clk);
    cfgWrEn = 1'b0; cfgRdEn = 1'b0;
    q = cfgRdData; v = cfgRdValid;
  endtask

  task automatic readCheck(input string req, input int f, input int idx);
    logic [31:0] q; logic v;
    access(1'b0, 1'b1, f, idx, 4'h0, 32'h0, q, v);
    check({req, " valid"}, 32'(v), 32'h1);
    check(req, q, mRead(f, idx));
  endtask

  task automatic writeOnly(input int f, input int idx, input logic [3:0] be, input logic [31:0] d);
    logic [31:0] q; logic v;
    access(1'b1, 1'b0, f, idx, be, d, q, v);
    mWrite(f, idx, be, d);
  endtask

  task automatic probeIo(input string req, input logic [15:0] a, input logic expIdx, input logic expDat);
    @(negedge clk);
    ioValid = 1'b1; ioAddr = a;
    #2;
    check({req, " index"}, 32'(legacyIndexSel), 32'(expIdx));
    check({req, " data"},  32'(legacyDataSel),  32'(expDat));
    ioValid = 1'b0;
  endtask

  task automatic checkEnables(input string req);
    for (int f = 0; f < 2; f++) begin
      check({req, " io"},  32'(sockIoEn[f]),     32'(mRegs[f][1][0]));
      check({req, " mem"}, 32'(sockMemEn[f]),    32'(mRegs[f][1][1]));
      check({req, " bm"},  32'(sockMasterEn[f]), 32'(mRegs[f][1][2]));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] q, exp; logic v;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 R6 R7 R11: reset state and constants through both functions
    for (int f = 0; f < 2; f++)
      for (int i = 0; i < 20; i++) readCheck("R1 R6 R7 R11 reset read", f, i);
    check("R1 legacy mode after reset", 32'(legacyMode), 32'h1);
    checkEnables("R1 enables after reset");

    // R2 R3: enable register of function 0 only
    writeOnly(0, 1, 4'hF, 32'hFFFF_FFFF);
    checkEnables("R2 R3 enables after fn0 write");
    readCheck("R2 cmd reads 0x7", 0, 1);
    readCheck("R3 fn1 cmd untouched", 1, 1);
    writeOnly(0, 1, 4'hF, 32'h0000_0005);
    checkEnables("R2 io+bm");

    // R3: bridge control and interrupt line independence
    writeOnly(1, 15, 4'hF, 32'hFFFF_FF12);
    readCheck("R11 fn1 intbc", 1, 15);
    readCheck("R3 fn0 intbc untouched", 0, 15);

    // R4: shared legacy base
    writeOnly(1, 17, 4'h3, 32'h0000_0271);
    readCheck("R4 legacy via fn0", 0, 17);
    readCheck("R4 legacy via fn1", 1, 17);

    // R5 alignment
    writeOnly(0, 4, 4'hF, 32'hFFFF_FFFF);
    readCheck("R5 socket base align", 0, 4);
    writeOnly(1, 8, 4'hF, 32'h1234_5FFF);
    readCheck("R5 mem window", 1, 8);
    writeOnly(1, 12, 4'hF, 32'h0000_ABCF);
    readCheck("R5 io window", 1, 12);

    // R7: writes to unimplemented and constant dwords
    writeOnly(0, 5, 4'hF, 32'hDEAD_BEEF);
    writeOnly(0, 3, 4'hF, 32'hDEAD_BEEF);
    writeOnly(1, 16, 4'hF, 32'hDEAD_BEEF);
    readCheck("R7 dword 5", 0, 5);
    readCheck("R6 header unchanged", 0, 3);
    readCheck("R7 dword 16", 1, 16);

    // R8: lane gating
    writeOnly(0, 9, 4'b0100, 32'hAABB_CCDD);
    readCheck("R8 single lane", 0, 9);

    // R9: legacy decode at current base 0x0270
    probeIo("R9 even port", 16'h0270, 1'b1, 1'b0);
    probeIo("R9 odd port",  16'h0271, 1'b0, 1'b1);
    probeIo("R9 miss",      16'h0272, 1'b0, 1'b0);
    // move base in same cycle region, old pair must miss
    writeOnly(0, 17, 4'h3, 32'h0000_03E0);
    probeIo("R9 old pair after move", 16'h0270, 1'b0, 1'b0);
    probeIo("R9 new pair", 16'h03E1, 1'b0, 1'b1);
    writeOnly(1, 17, 4'hF, 32'h0000_0001);
    check("R9 card-bus mode", 32'(legacyMode), 32'h0);
    probeIo("R9 no decode at zero", 16'h0000, 1'b0, 1'b0);

    // R10: read and write in the same cycle return the old value
    exp = mRead(0, 10);
    access(1'b1, 1'b1, 0, 10, 4'hF, 32'h5555_5000, q, v);
    check("R10 read-before-write", q, exp);
    mWrite(0, 10, 4'hF, 32'h5555_5000);
    readCheck("R10 new value visible", 0, 10);

    // random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 400; n++) begin
      int f, idx;
      logic wr;
      logic [3:0] be;
      logic [31:0] d;
      f   = int'($urandom % 2);
      idx = int'($urandom % 20);
      wr  = 1'($urandom % 2);
      be  = 4'($urandom);
      d   = $urandom;
      if (idx == 17 && ($urandom % 4) == 0) d[15:1] = '0;
      exp = mRead(f, idx);
      access(wr, 1'b1, f, idx, be, d, q, v);
      check("R3 R4 R8 R10 random read", q, exp);
      if (wr) mWrite(f, idx, be, d);
      checkEnables("R2 random enables");
      check("R9 random mode", 32'(legacyMode), 32'(mLeg[15:1] != 0));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule